// File: doc/BRIEF.md
# Synchronous Burst Cache RAM with Lane Writes

This block is a synchronous static RAM for cache data. Each word is 18 bits wide and is split into two 9-bit lanes. On every rising clock edge it takes in the address, write data and write controls. The internal address then either reloads from the address input, steps through a 4-word burst, or holds.

Two address strobes can start a burst. One is the processor-side strobe and has priority; the other is the controller-side strobe. Once a burst is running, a 2-bit counter walks the two low address bits while the advance input is high. A static mode pin picks the walk order: linear or interleaved.

Writes reach the word addressed for the coming cycle. They can target either lane alone or the whole word. Reads are flow-through, so the array word at the current address drives the output combinationally. An asynchronous output enable gates the output.

Top module: `burst_sram`

## Requirements
- R1: A word is two 9-bit lanes (lane 0 = bits 8:0, lane 1 = bits 17:9). A lane write changes only the bits of its own lane.
- R2: On an edge where either strobe is high, the current address becomes the address input and the burst count returns to zero.
- R3: On an edge where the processor-side strobe `stb_cpu` is high, no write happens, whatever the other inputs are (including when both strobes are high).
- R4: On an edge with no strobe and `adv` low, the current address holds.
- R5: In linear order (`order_il`=0) the low two address bits are (start + count) mod 4. The upper bits keep the values loaded at the burst start.
- R6: In interleaved order (`order_il`=1) the low two bits are start XOR count. The pin is not registered.
- R7: After the fourth beat, further advances wrap around inside the same 4-word block.
- R8: With `wr_all` high (and `stb_cpu` low), both lanes are written, whatever the values of `wr_en` and `lane_wr`.
- R9: Lane i is written only when `lane_wr[i]` and `wr_en` are both high. With `wr_en` low, `lane_wr` has no effect.
- R10: Reads are flow-through. After an edge, `dout` shows the array word at the new current address, including data written at that edge.
- R11: While `oe` is low, `dout_vld` is 0 and `dout` is high impedance. `oe` acts without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset of the address state |
| addr | input | AW | External word address |
| stb_cpu | input | 1 | Processor-side burst start; has priority and blocks writes |
| stb_ctl | input | 1 | Controller-side burst start |
| adv | input | 1 | Step the burst counter |
| wr_en | input | 1 | Write enable for the lane writes |
| lane_wr | input | LANES | Per-lane write select |
| wr_all | input | 1 | Write the whole word |
| din | input | LANES*LANE_W | Write data |
| order_il | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe | input | 1 | Asynchronous output enable |
| dout | output | LANES*LANE_W | Flow-through read data, high impedance when disabled |
| dout_vld | output | 1 | Output is driven |

## Verification
The array is first filled through whole-word writes started by the controller strobe. Each of these writes must read back in the cycle after its edge, which tells flow-through apart from a registered read.

Bursts are then started at a start offset that is not zero. They are advanced past the fourth beat in both orders. Because the start offset is nonzero, linear and interleaved order give different address sequences, and a wrong wrap would leave the 4-word block.

The write cases are mixed to separate the decode terms:
- a single lane, a lane write with the enable low, and a whole-word write;
- processor-strobe cycles with writes pending, alone and together with the controller strobe;
- held cycles, and toggles of the output enable in the middle of a cycle.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

  // Low two address bits of a burst beat.
  function automatic logic [1:0] beat_offset(input logic [1:0] start,
                                             input logic [1:0] count,
                                             input logic       interleave);
    logic [1:0] r;
    if (interleave) r = start ^ count;
    else            r = start + count;
    return r;
  endfunction

  // Lane write mask for one edge.
  function automatic logic [1:0] lane_mask(input logic       blocked,
                                           input logic       whole,
                                           input logic       enable,
                                           input logic [1:0] sel);
    logic [1:0] m;
    if (blocked)     m = 2'b00;
    else if (whole)  m = 2'b11;
    else if (enable) m = sel;
    else             m = 2'b00;
    return m;
  endfunction

endpackage

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_sram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] addr_in,
  input  logic          interleave,
  output logic [AW-1:0] cur_addr,
  output logic [AW-1:0] next_addr
);
  logic [AW-1:0] base_q, base_d;
  logic [1:0]    cnt_q, cnt_d;

  always_comb begin
    base_d = base_q;
    cnt_d  = cnt_q;
    if (load) begin
      base_d = addr_in;
      cnt_d  = 2'd0;
    end else if (step) begin
      cnt_d = cnt_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= 2'd0;
    end else begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end

  assign cur_addr  = {base_q[AW-1:2], beat_offset(base_q[1:0], cnt_q, interleave)};
  assign next_addr = {base_d[AW-1:2], beat_offset(base_d[1:0], cnt_d, interleave)};
endmodule

// File: rtl/sram_lane.sv
module sram_lane #(
  parameter int AW     = 6,
  parameter int LANE_W = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [LANE_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int AW     = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [AW-1:0]           addr,
  input  logic                    stb_cpu,
  input  logic                    stb_ctl,
  input  logic                    adv,
  input  logic                    wr_en,
  input  logic [LANES-1:0]        lane_wr,
  input  logic                    wr_all,
  input  logic [LANES*LANE_W-1:0] din,
  input  logic                    order_il,
  input  logic                    oe,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_vld
);
  localparam int WW = LANES * LANE_W;

  // Named internal events, observed by the checker.
  logic          load_evt;
  logic          step_evt;
  logic [AW-1:0] cur_addr;
  logic [AW-1:0] next_addr;
  logic [LANES-1:0] wr_lanes;
  logic [WW-1:0] rd_word;

  assign load_evt = stb_cpu | stb_ctl;
  assign step_evt = adv & ~load_evt;

  burst_addr_gen #(.AW(AW)) u_agen (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load_evt),
    .step       (step_evt),
    .addr_in    (addr),
    .interleave (order_il),
    .cur_addr   (cur_addr),
    .next_addr  (next_addr)
  );

  generate
    if (LANES == 2) begin : g_mask2
      assign wr_lanes = lane_mask(stb_cpu, wr_all, wr_en, lane_wr);
    end else begin : g_maskn
      always_comb begin
        if (stb_cpu)     wr_lanes = '0;
        else if (wr_all) wr_lanes = '1;
        else if (wr_en)  wr_lanes = lane_wr;
        else             wr_lanes = '0;
      end
    end
  endgenerate

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    sram_lane #(.AW(AW), .LANE_W(LANE_W)) u_lane (
      .clk   (clk),
      .we    (wr_lanes[i] & rst_n),
      .waddr (next_addr),
      .wdata (din[i*LANE_W +: LANE_W]),
      .raddr (cur_addr),
      .rdata (rd_word[i*LANE_W +: LANE_W])
    );
  end

  assign dout     = oe ? rd_word : {WW{1'bz}};
  assign dout_vld = oe;
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
  parameter int AW    = 6,
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stb_cpu,
  input logic             stb_ctl,
  input logic             adv,
  input logic             wr_all,
  input logic             order_il,
  input logic [AW-1:0]    addr,
  input logic [AW-1:0]    cur_addr,
  input logic [LANES-1:0] wr_lanes
);
  assert_cpu_blocks_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stb_cpu |-> wr_lanes == '0);

  assert_strobe_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_cpu || stb_ctl) |=> cur_addr == $past(addr));

  assert_idle_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb_cpu && !stb_ctl && !adv) |=> (order_il != $past(order_il)) || (cur_addr == $past(cur_addr)));

  assert_block_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !stb_cpu && !stb_ctl) |=> cur_addr[AW-1:2] == $past(cur_addr[AW-1:2]));

  assert_global_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_all && !stb_cpu) |-> wr_lanes == '1);
endmodule

bind burst_sram burst_sram_chk #(.AW(AW), .LANES(LANES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .stb_cpu  (stb_cpu),
  .stb_ctl  (stb_ctl),
  .adv      (adv),
  .wr_all   (wr_all),
  .order_il (order_il),
  .addr     (addr),
  .cur_addr (cur_addr),
  .wr_lanes (wr_lanes)
);

// File: tb/burst_sram_test.sv
module burst_sram_test;
  localparam int PERIOD = 10;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 0;
  logic rst_n = 0;
  logic [AW-1:0] addr = '0;
  logic stb_cpu = 0, stb_ctl = 0, adv = 0, wr_en = 0, wr_all = 0;
  logic [1:0] lane_wr = '0;
  logic [17:0] din = '0;
  logic order_il = 0, oe = 0;
  wire  [17:0] dout;
  wire         dout_vld;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference model state
  logic [17:0] mm [DEPTH];
  int m_base = 0;
  int m_cnt  = 0;

  always #(PERIOD/2) clk = ~clk;

  burst_sram uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .stb_cpu(stb_cpu), .stb_ctl(stb_ctl),
    .adv(adv), .wr_en(wr_en), .lane_wr(lane_wr), .wr_all(wr_all), .din(din),
    .order_il(order_il), .oe(oe), .dout(dout), .dout_vld(dout_vld)
  );

  function automatic int model_addr(input int base, input int cnt, input logic il);
    int s, lo;
    s = base % 4;
    lo = il ? (s ^ cnt) : ((s + cnt) % 4);
    return (base - s) + lo;
  endfunction

  function automatic logic [17:0] pat(input int i);
    return 18'((i * 37 + 11) * 2053) ^ 18'h2A5A5;
  endfunction

  task automatic check(input string tag, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive at the falling edge, update the model at the rising edge,
  // compare at the next falling edge.
  task automatic cyc(input logic c, input logic k, input logic a, input logic we,
                     input logic [1:0] lw, input logic all, input logic [17:0] d,
                     input int ad, input string tag);
    int cur;
    logic [1:0] m;
    stb_cpu = c; stb_ctl = k; adv = a; wr_en = we; lane_wr = lw;
    wr_all = all; din = d; addr = AW'(ad);
    @(posedge clk);
    if (c || k) begin m_base = ad; m_cnt = 0; end
    else if (a) m_cnt = (m_cnt + 1) % 4;
    cur = model_addr(m_base, m_cnt, order_il);
    if (c) m = 2'b00;
    else if (all) m = 2'b11;
    else if (we) m = lw;
    else m = 2'b00;
    if (m[0]) mm[cur][8:0]  = d[8:0];
    if (m[1]) mm[cur][17:9] = d[17:9];
    @(negedge clk);
    if (oe) begin
      check({tag, " vld"}, {17'd0, dout_vld}, 18'd1);
      check(tag, dout, mm[cur]);
    end else begin
      check({tag, " vld"}, {17'd0, dout_vld}, 18'd0);
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 reset state with output disabled
    check("R11 reset vld", {17'd0, dout_vld}, 18'd0);

    // Fill with whole-word writes via controller strobe (R8, R10)
    oe = 1;
    for (int i = 0; i < DEPTH; i++)
      cyc(0, 1, 0, 0, 2'b00, 1, pat(i), i, "R8_R10 fill");

    // Linear burst from offset 2, six beats to wrap (R5, R7)
    order_il = 0;
    cyc(1, 0, 0, 0, 2'b00, 0, '0, 22, "R2 cpu load");
    for (int b = 0; b < 6; b++)
      cyc(0, 0, 1, 0, 2'b00, 0, '0, 0, "R5_R7 linear beat");

    // Interleaved burst from offset 1 (R6, R7)
    order_il = 1;
    cyc(0, 1, 0, 0, 2'b00, 0, '0, 41, "R2 ctl load");
    for (int b = 0; b < 6; b++)
      cyc(0, 0, 1, 0, 2'b00, 0, '0, 0, "R6_R7 interleaved beat");

    // Asynchronous mode pin: count is 2 now, flip order mid-cycle (R6)
    order_il = 0;
    #1;
    check("R6 async order", dout, mm[model_addr(m_base, m_cnt, 0)]);

    // Lane writes during a burst (R1, R9)
    cyc(0, 1, 0, 1, 2'b01, 0, 18'h3FFFF, 13, "R1 lane0 write");
    cyc(0, 0, 1, 1, 2'b10, 0, 18'h15555, 0, "R1 lane1 write");
    cyc(0, 0, 1, 0, 2'b11, 0, 18'h00000, 0, "R9 no enable");
    cyc(0, 0, 0, 1, 2'b11, 0, 18'h2BEEF, 0, "R9 both lanes");

    // Global write ignores wr_en and lane_wr (R8)
    cyc(0, 0, 1, 0, 2'b00, 1, 18'h1A5C3, 0, "R8 global");

    // Processor strobe blocks writes, alone and with the controller strobe (R3)
    cyc(1, 0, 0, 1, 2'b11, 1, 18'h00F0F, 5, "R3 cpu blocks");
    cyc(1, 1, 0, 1, 2'b11, 1, 18'h0F0F0, 9, "R3 both strobes");

    // Hold without strobe or advance (R4)
    cyc(0, 0, 0, 0, 2'b00, 0, '0, 60, "R4 hold");
    cyc(0, 0, 0, 0, 2'b00, 0, '0, 3, "R4 hold again");

    // Output enable acts mid-cycle (R11)
    oe = 0;
    #1;
    check("R11 oe off vld", {17'd0, dout_vld}, 18'd0);
    check("R11 oe off z", 18'(dout === {18{1'bz}}), 18'd1);
    oe = 1;
    #1;
    check("R11 oe on", dout, mm[model_addr(m_base, m_cnt, order_il)]);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule